// File: doc/BRIEF.md
# Dual-Mode Down-Counter / Timer with Ready Flag

This block is a down-counter with a programmable width (16 bits by default) and two modes of operation. In timer mode it runs without stopping. Each time it passes zero it reloads the preload value and toggles a square-wave output. The ready flag rises once per full period of that wave. In counter mode a start command loads the preload value. The count then falls by one per tick, and the ready flag rises on the tick that brings it to zero. The count then wraps and keeps falling until a stop command arrives.

The count advances only on cycles where the external `tick` enable is high. Clock-source selection and prescaling sit outside the block. The stop command behaves differently in each mode. In counter mode it halts the count and clears the flag. In timer mode it only clears the flag, and the timer keeps running. Every pin is a plain level or pulse control or status signal. The block has no streaming data path, so no valid/ready handshake or back-pressure applies.

Top module: `ct_dual_timer`

## Requirements
- R1: After reset, `wave_out` is 1, `ready` is 0 and the counter-mode count is halted.
- R2: In timer mode (`mode_timer`=1), after a start the count falls from the preload value P by one per tick. The tick that finds it at zero reloads P and inverts `wave_out`, so each half period is P+1 ticks.
- R3: In timer mode `ready` is set on the reload tick that drives `wave_out` from 0 to 1, i.e. once per full period of 2(P+1) ticks.
- R4: In timer mode a stop pulse clears `ready` but does not halt the count. A tick in the same cycle still advances it, and `wave_out` keeps its schedule.
- R5: In counter mode (`mode_timer`=0), a start loads P and each later tick decrements it. `ready` is set on the tick that brings the count to 0x0000.
- R6: In counter mode the count wraps from 0x0000 to 0xFFFF and keeps counting. With P=0, `ready` sets after exactly 65536 ticks.
- R7: In counter mode a stop pulse halts the count and clears `ready`. Later ticks have no effect until the next start.
- R8: A start while running reloads P and restarts the count. A start also forces `wave_out` to 1.
- R9: When start and stop arrive in the same cycle, stop takes effect and start is ignored.
- R10: With `tick` low and no start or stop, the count, `wave_out` and `ready` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| preload | input | 16 | Reload / start value |
| mode_timer | input | 1 | 1 = timer mode, 0 = counter mode |
| start | input | 1 | Load preload and start counting (pulse) |
| stop | input | 1 | Clear ready; also halts in counter mode (pulse) |
| wave_out | output | 1 | Square-wave output |
| ready | output | 1 | Counter-ready flag |

## Verification
The count register has no port of its own, so a wrong count shows up only at the next zero crossing. In timer mode the error appears as a toggle of `wave_out` on the wrong tick, at most P+1 ticks later. In counter mode it appears as `ready` rising early or late. A halt state that fails to take effect shows up as a spurious `ready` after a stop. The bench uses a behavioural model with small preload values so that each crossing comes within a few cycles, and compares both outputs on every clock. Only the wrap case needs the full 65536-tick run.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned CT_DEFAULT_WIDTH = 16;

  typedef enum logic {
    CT_MODE_COUNTER = 1'b0,
    CT_MODE_TIMER   = 1'b1
  } ct_mode_e;
endpackage

// File: rtl/ct_count_reg.sv
module ct_count_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             reload,
  input  logic             step,
  input  logic [WIDTH-1:0] load_val,
  output logic             at_zero,
  output logic             at_one
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load || reload)  cnt_q <= load_val;
    else if (step)            cnt_q <= cnt_q - ONE;
  end

  assign at_zero = (cnt_q == '0);
  assign at_one  = (cnt_q == ONE);

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val))); // R8

  AST_DECREMENT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !reload) |=> (cnt_q == $past(cnt_q) - ONE)); // R6
endmodule

// File: rtl/ct_run_ctrl.sv
module ct_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic halt,
  output logic running
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= 1'b0;
    else if (halt) run_q <= 1'b0;
    else if (load) run_q <= 1'b1;
  end

  assign running = run_q;

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !run_q); // R7
endmodule

// File: rtl/ct_out_flags.sv
module ct_out_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic reload,
  input  logic term,
  input  logic clr_ready,
  output logic wave,
  output logic ready
);
  logic wave_q, ready_q, set_ready;

  assign set_ready = (reload && !wave_q) || term;

  always_ff @(posedge clk) begin
    if (!rst_n)      wave_q <= 1'b1;
    else if (load)   wave_q <= 1'b1;
    else if (reload) wave_q <= ~wave_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ready_q <= 1'b0;
    else if (clr_ready) ready_q <= 1'b0;
    else if (set_ready) ready_q <= 1'b1;
  end

  assign wave  = wave_q;
  assign ready = ready_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ready |=> !ready_q); // R4
endmodule

// File: rtl/ct_dual_timer.sv
module ct_dual_timer
  import ct_pkg::*;
#(
  parameter int unsigned WIDTH = CT_DEFAULT_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [WIDTH-1:0] preload,
  input  logic             mode_timer,
  input  logic             start,
  input  logic             stop,
  output logic             wave_out,
  output logic             ready
);
  ct_mode_e mode;
  logic load, halt, go, step, reload, term, running, at_zero, at_one;

  assign mode   = ct_mode_e'(mode_timer);
  assign load   = start && !stop;
  assign halt   = stop && (mode == CT_MODE_COUNTER);
  assign go     = (mode == CT_MODE_TIMER) || running;
  assign step   = tick && go && !load && !halt;
  assign reload = step && (mode == CT_MODE_TIMER) && at_zero;
  assign term   = step && (mode == CT_MODE_COUNTER) && at_one;

  ct_count_reg #(.WIDTH(WIDTH)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .reload   (reload),
    .step     (step),
    .load_val (preload),
    .at_zero  (at_zero),
    .at_one   (at_one)
  );

  ct_run_ctrl u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .halt    (halt),
    .running (running)
  );

  ct_out_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .reload    (reload),
    .term      (term),
    .clr_ready (stop),
    .wave      (wave_out),
    .ready     (ready)
  );

  AST_IDLE_HOLDS_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start && !stop) |=> $stable(wave_out)); // R10

  AST_READY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tick)); // R3

  AST_START_WAVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> wave_out); // R8

  AST_STOP_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !ready); // R9
endmodule

// File: tb/ct_dual_timer_bench.sv
module ct_dual_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] preload = '0;
  logic        mode_timer = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        wave_out, ready;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_run = 0;
  bit m_wave = 1;
  bit m_ready = 0;

  always #4 clk = ~clk;

  ct_dual_timer u_ct_dual_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .preload(preload),
    .mode_timer(mode_timer), .start(start), .stop(stop),
    .wave_out(wave_out), .ready(ready)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_wave = 1; m_ready = 0;
    end else begin
      bit stepping;
      stepping = 0;
      if (stop) begin
        m_ready = 0;
        if (!mode_timer) m_run = 0;
        else if (tick) stepping = 1;
      end else if (start) begin
        m_cnt = int'(preload); m_run = 1; m_wave = 1;
      end else if (tick && (mode_timer || m_run)) begin
        stepping = 1;
      end
      if (stepping) begin
        if (mode_timer) begin
          if (m_cnt == 0) begin
            m_cnt = int'(preload);
            if (!m_wave && !stop) m_ready = 1;
            m_wave = !m_wave;
          end else m_cnt = m_cnt - 1;
        end else begin
          if (m_cnt == 1) m_ready = 1;
          m_cnt = (m_cnt == 0) ? 65535 : m_cnt - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (wave_out !== m_wave || ready !== m_ready) begin
        errors++;
        $display("FAIL %s model: wave=%0b ready=%0b expected wave=%0b ready=%0b",
                 mode_timer ? "R2" : "R5", wave_out, ready, m_wave, m_ready);
      end
    end
  end

  task automatic cyc(input bit t, input bit s, input bit p);
    tick = t; start = s; stop = p;
    @(negedge clk);
    tick = 0; start = 0; stop = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0);
  endtask

  task automatic chk(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wave", wave_out, 1'b1);
    chk("R1 ready", ready, 1'b0);
    ticks(5);
    chk("R1 idle ready", ready, 1'b0);

    // timer mode, P=3
    mode_timer = 1; preload = 16'd3;
    cyc(0, 1, 0);
    ticks(3);
    chk("R2 before half", wave_out, 1'b1);
    ticks(1);
    chk("R2 half period", wave_out, 1'b0);
    chk("R3 no ready mid", ready, 1'b0);
    ticks(4);
    chk("R3 full period wave", wave_out, 1'b1);
    chk("R3 full period ready", ready, 1'b1);
    cyc(1, 0, 1);
    chk("R4 stop clears", ready, 1'b0);
    ticks(2);
    chk("R4 still high", wave_out, 1'b1);
    ticks(1);
    chk("R4 timer kept running", wave_out, 1'b0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0);
    chk("R10 hold wave", wave_out, 1'b0);
    chk("R10 hold ready", ready, 1'b0);
    cyc(1, 1, 0);
    chk("R8 restart wave high", wave_out, 1'b1);
    ticks(8);
    chk("R8 restart period", ready, 1'b1);
    cyc(0, 0, 1);

    // counter mode, P=5
    mode_timer = 0; preload = 16'd5;
    cyc(0, 1, 0);
    ticks(4);
    chk("R5 before terminal", ready, 1'b0);
    ticks(1);
    chk("R5 terminal", ready, 1'b1);
    cyc(0, 0, 1);
    chk("R7 stop clears", ready, 1'b0);
    cyc(0, 1, 0);
    ticks(2);
    cyc(0, 0, 1);
    ticks(10);
    chk("R7 halted", ready, 1'b0);
    cyc(0, 1, 0);
    ticks(2);
    cyc(0, 1, 0);
    ticks(4);
    chk("R8 restart no early", ready, 1'b0);
    ticks(1);
    chk("R8 restart terminal", ready, 1'b1);
    cyc(0, 0, 1);
    cyc(0, 1, 1);
    ticks(10);
    chk("R9 stop beats start", ready, 1'b0);

    // wrap with P=0
    preload = 16'd0;
    cyc(0, 1, 0);
    ticks(65535);
    chk("R6 before wrap terminal", ready, 1'b0);
    ticks(1);
    chk("R6 wrap terminal", ready, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule